// File: doc/BRIEF.md
# Delay-Tap Stepper

This block walks two tap-delay lines, one for the read path and one for the write path, to requested tap settings. The delay lines cannot be loaded with a value and cannot be read back. They accept only a reset and single increment or decrement steps. The block therefore keeps its own copy of each tap position.

A `go` strobe does three things. It captures the two targets and clamps each one to the legal tap range. It then puts both lines into a known state with a reset pulse. After that it issues one step at a time, first until the read line reaches its target and then until the write line reaches its target.

Every pulse has three phases: setup, clock high and clock low. Each phase lasts a fixed number of cycles, set by a parameter. When the sequence finishes and both tracked positions equal their targets, `done` is raised.

Top module: `tap_stepper`

## Requirements
- R1: In the cycle after `go` is sampled high while the block is idle, both `rd_rst` and `wr_rst` go high and `step_clk` stays low. While both resets are held, `step_clk` pulses high exactly once. Neither chip-enable is asserted during this reset sequence, and both resets are released when it ends.
- R2: The reset sequence sets the tracked read position to `RD_INIT` (default 16) and the tracked write position to `WR_INIT` (default 32). All later steps count from these values.
- R3: Each step has three phases in this order: setup, clock high, clock low.
  - In the setup phase exactly one chip-enable is raised and `step_inc` is driven. `step_inc`=1 means increment (target above current position) and 0 means decrement (target below).
  - The clock-high phase raises `step_clk`; the clock-low phase lowers it.
  - Chip-enable and `step_inc` do not change from setup through clock low.
- R4: All read-line steps finish before the first write-line step.
- R5: `rd_ce` and `wr_ce` are separate outputs and are never high together. `step_inc` and `step_clk` are shared by both lines.
- R6: Each phase, whether part of the reset or part of a step, lasts `PHASE_CYC` cycles.
  - There is one decision cycle before each step and one after the last step.
  - So `done` is low for 3·`PHASE_CYC` + n·(3·`PHASE_CYC`+1) + 1 cycles after `go`, where n is the total number of steps.
- R7: A target above `TAP_MAX` (default 47) is replaced by `TAP_MAX` when it is captured.
- R8: `done` is low from reset until the first sequence completes. After that it is high only while the block is idle and both tracked positions equal the captured targets. Targets are captured only on an accepted `go`, so changing the target inputs alone does not drop `done`.
- R9: A `go` received while a sequence is running is ignored. The running sequence finishes at its original targets and on its original schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start strobe, accepted only while idle |
| rd_target | input | TAP_W | Requested read-line tap |
| wr_target | input | TAP_W | Requested write-line tap |
| rd_rst | output | 1 | Read-line reset |
| wr_rst | output | 1 | Write-line reset |
| rd_ce | output | 1 | Read-line chip-enable |
| wr_ce | output | 1 | Write-line chip-enable |
| step_inc | output | 1 | Shared step direction, 1 = increment |
| step_clk | output | 1 | Shared step clock |
| done | output | 1 | Both lines settled at their targets |

## Verification
The bench rebuilds both tap positions from the output pins alone. It counts each rising edge of `step_clk` together with the chip-enable and direction present at that edge, starting from the reset values. The tap positions it derives are compared with clamped targets that the bench computes itself.

The corner cases covered, and how a faulty design would show up:
- Targets above the legal range: a design without the clamp steps past the end of the line.
- Targets equal to the reset positions: a design that fails to skip the step loop issues a stray step.
- Targets at zero: a design with a wrong direction bit walks the wrong way and never converges.
- A second `go` during a run: a design that accepts it restarts, so its step count and its `done` timing no longer match the formula.
- Interleaved read and write steps or a shifted chip-enable: a design that breaks the phase ordering shows a chip-enable changing while the clock is high.

// File: rtl/tap_stepper.sv
module tap_stepper #(
  parameter int TAP_W     = 6,
  parameter int TAP_MAX   = 47,
  parameter int RD_INIT   = 16,
  parameter int WR_INIT   = 32,
  parameter int PHASE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [TAP_W-1:0] rd_target,
  input  logic [TAP_W-1:0] wr_target,
  output logic             rd_rst,
  output logic             wr_rst,
  output logic             rd_ce,
  output logic             wr_ce,
  output logic             step_inc,
  output logic             step_clk,
  output logic             done
);

  localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [TAP_W-1:0] MAXV  = TAP_W'(TAP_MAX);
  localparam logic [TAP_W-1:0] RD_RV = TAP_W'(RD_INIT);
  localparam logic [TAP_W-1:0] WR_RV = TAP_W'(WR_INIT);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(PHASE_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RS_SET, S_RS_HI, S_RS_LO, S_PICK, S_ST_SET, S_ST_HI, S_ST_LO
  } state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [TAP_W-1:0] rd_pos, wr_pos, rd_tgt, wr_tgt;
  logic             sel_wr, inc, valid;

  function automatic logic [TAP_W-1:0] clamp(input logic [TAP_W-1:0] t);
    return (t > MAXV) ? MAXV : t;
  endfunction

  wire phase_end = (cnt == LAST);
  wire rd_diff   = (rd_pos != rd_tgt);
  wire wr_diff   = (wr_pos != wr_tgt);
  wire stepping  = (state == S_ST_SET) || (state == S_ST_HI) || (state == S_ST_LO);
  wire resetting = (state == S_RS_SET) || (state == S_RS_HI) || (state == S_RS_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      rd_pos <= RD_RV;
      wr_pos <= WR_RV;
      rd_tgt <= RD_RV;
      wr_tgt <= WR_RV;
      sel_wr <= 1'b0;
      inc    <= 1'b0;
      valid  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          rd_tgt <= clamp(rd_target);
          wr_tgt <= clamp(wr_target);
          cnt    <= '0;
          state  <= S_RS_SET;
        end
        S_RS_SET, S_RS_HI, S_ST_SET, S_ST_HI: begin
          if (phase_end) begin
            cnt   <= '0;
            state <= state_t'(state + 3'd1);
          end else cnt <= cnt + CNT_W'(1);
        end
        S_RS_LO: begin
          if (phase_end) begin
            cnt    <= '0;
            rd_pos <= RD_RV;
            wr_pos <= WR_RV;
            valid  <= 1'b1;
            state  <= S_PICK;
          end else cnt <= cnt + CNT_W'(1);
        end
        S_PICK: begin
          if (rd_diff) begin
            sel_wr <= 1'b0;
            inc    <= (rd_pos < rd_tgt);
            state  <= S_ST_SET;
          end else if (wr_diff) begin
            sel_wr <= 1'b1;
            inc    <= (wr_pos < wr_tgt);
            state  <= S_ST_SET;
          end else state <= S_IDLE;
        end
        S_ST_LO: begin
          if (phase_end) begin
            cnt <= '0;
            if (sel_wr) wr_pos <= inc ? wr_pos + TAP_W'(1) : wr_pos - TAP_W'(1);
            else        rd_pos <= inc ? rd_pos + TAP_W'(1) : rd_pos - TAP_W'(1);
            state <= S_PICK;
          end else cnt <= cnt + CNT_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rd_rst   = resetting;
  assign wr_rst   = resetting;
  assign step_clk = (state == S_RS_HI) || (state == S_ST_HI);
  assign rd_ce    = stepping && !sel_wr;
  assign wr_ce    = stepping && sel_wr;
  assign step_inc = stepping && inc;
  assign done     = (state == S_IDLE) && valid && !rd_diff && !wr_diff;

  AST_RST_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rst |-> (!rd_ce && !wr_ce)); // R1
  AST_CE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    step_clk |=> ($stable(rd_ce) && $stable(wr_ce) && $stable(step_inc))); // R3
  AST_DIR_TOWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ce && step_clk) |-> (step_inc == (rd_pos < rd_tgt))); // R3
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ce |-> (rd_pos == rd_tgt)); // R4
  AST_ONE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_ce, wr_ce})); // R5
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (rd_pos <= MAXV && wr_pos <= MAXV && rd_tgt <= MAXV && wr_tgt <= MAXV)); // R7
  AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rst || rd_ce || wr_ce) |-> !done); // R8

endmodule

// File: tb/tap_stepper_test.sv
module tap_stepper_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 6;
  localparam int TMAX = 47;
  localparam int P = 3;

  logic clk = 0, rst_n = 0, go = 0;
  logic [TW-1:0] rd_target = 0, wr_target = 0;
  logic rd_rst, wr_rst, rd_ce, wr_ce, step_inc, step_clk, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  tap_stepper #(.TAP_W(TW), .TAP_MAX(TMAX), .RD_INIT(16), .WR_INIT(32), .PHASE_CYC(P)) uut (
    .clk(clk), .rst_n(rst_n), .go(go), .rd_target(rd_target), .wr_target(wr_target),
    .rd_rst(rd_rst), .wr_rst(wr_rst), .rd_ce(rd_ce), .wr_ce(wr_ce),
    .step_inc(step_inc), .step_clk(step_clk), .done(done));

  int checks = 0, fails = 0;
  int mchecks = 0, mfails = 0;
  bit finished = 0;

  // Pin-level monitor: rebuilds tap positions from the pulses
  int m_rd = 0, m_wr = 0, m_steps = 0, hi_len = 0;
  bit wr_seen = 0, prev_clk = 0, prev_rce = 0, prev_wce = 0, prev_inc = 0;
  bit h_rce = 0, h_wce = 0, h_inc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (step_clk && !prev_clk) begin
        if (rd_rst && wr_rst) begin
          mchecks++;
          if (rd_ce || wr_ce) begin mfails++; $display("FAIL R1: ce during reset pulse rd=%0b wr=%0b exp 0", rd_ce, wr_ce); end
          m_rd = 16; m_wr = 32; wr_seen = 0; m_steps = 0;
        end else begin
          m_steps++;
          mchecks++;
          if ((rd_ce ^ wr_ce) != 1'b1) begin mfails++; $display("FAIL R5: ce pair rd=%0b wr=%0b exp exactly one", rd_ce, wr_ce); end
          mchecks++;
          if (rd_ce != prev_rce || wr_ce != prev_wce || step_inc != prev_inc) begin
            mfails++; $display("FAIL R3: setup phase missing ce/inc %0b%0b%0b exp %0b%0b%0b", prev_rce, prev_wce, prev_inc, rd_ce, wr_ce, step_inc);
          end
          if (rd_ce) begin
            mchecks++;
            if (wr_seen) begin mfails++; $display("FAIL R4: read step after write step, got 1 exp 0"); end
            m_rd += step_inc ? 1 : -1;
          end
          if (wr_ce) begin wr_seen = 1; m_wr += step_inc ? 1 : -1; end
        end
        h_rce = rd_ce; h_wce = wr_ce; h_inc = step_inc;
      end
      if (step_clk) begin
        hi_len++;
        mchecks++;
        if (rd_ce != h_rce || wr_ce != h_wce || step_inc != h_inc) begin
          mfails++; $display("FAIL R3: ce/inc moved while clock high %0b%0b%0b exp %0b%0b%0b", rd_ce, wr_ce, step_inc, h_rce, h_wce, h_inc);
        end
      end else if (prev_clk) begin
        mchecks++;
        if (hi_len != P) begin mfails++; $display("FAIL R6: clock high %0d cycles exp %0d", hi_len, P); end
        hi_len = 0;
      end
      prev_clk = step_clk; prev_rce = rd_ce; prev_wce = wr_ce; prev_inc = step_inc;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: got %0d exp %0d", req, act, exp); end
  endtask

  function automatic int clampv(input int t);
    return (t > TMAX) ? TMAX : t;
  endfunction

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic int exp_cycles(input int n);
    return 3*P + n*(3*P + 1) + 1;
  endfunction

  task automatic run(input int rt, input int wt, input bit busy_go);
    int cyc = 0;
    int er = clampv(rt), ew = clampv(wt);
    int n = absd(er, 16) + absd(ew, 32);
    @(negedge clk);
    rd_target = TW'(rt); wr_target = TW'(wt); go = 1;
    @(negedge clk);
    go = 0;
    check(rd_rst && wr_rst && !step_clk, "R1 reset starts", {rd_rst, wr_rst, step_clk}, 3'b110);
    while (!done && cyc < 5000) begin
      cyc++;
      if (busy_go && cyc == 5) begin rd_target = TW'(er ^ 5); wr_target = TW'(ew ^ 3); go = 1; end
      else go = 0;
      @(negedge clk);
    end
    go = 0;
    check(cyc == exp_cycles(n), busy_go ? "R9 busy go timing" : "R6 sequence length", cyc, exp_cycles(n));
    check(m_rd == er, rt > TMAX ? "R7 read clamp" : "R2/R3 read position", m_rd, er);
    check(m_wr == ew, wt > TMAX ? "R7 write clamp" : "R2/R3 write position", m_wr, ew);
    check(m_steps == n, "R3 step count", m_steps, n);
    check(!rd_rst && !wr_rst && !step_clk, "R1 released", {rd_rst, wr_rst, step_clk}, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!done && !rd_rst && !wr_rst && !rd_ce && !wr_ce && !step_clk && !step_inc,
          "R8 reset state", {done, rd_rst, wr_rst, rd_ce, wr_ce, step_clk, step_inc}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!done, "R8 done low before first run", done, 0);

    run(16, 32, 0);
    run(20, 30, 0);
    run(0, 0, 0);
    run(63, 50, 0);
    run(TMAX, TMAX, 0);
    run(10, 40, 1);

    rd_target = 6'd1; wr_target = 6'd2;
    repeat (5) @(negedge clk);
    check(done, "R8 done holds with new inputs, no go", done, 1);
    check(m_rd == 10 && m_wr == 40, "R9 no extra steps", m_rd*100 + m_wr, 1040);

    for (int k = 0; k < 14; k++) begin
      run(int'($urandom_range(63, 0)), int'($urandom_range(63, 0)), k % 5 == 4);
    end

    checks += mchecks; fails += mfails;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks += mchecks + 1; fails += mfails + 1;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule